// File: doc/BRIEF.md
# Asynchronous Host Bus Register Slave

This block lets a host processor read and write a small bank of registers inside the FPGA over a plain parallel bus that carries no clock. The host presents an address, drives one of three active-low chip selects, and pulses either an active-low read enable or an active-low write enable. Every one of these inputs is resampled by the FPGA clock through a two-flop synchronizer before any decision is taken on it. The block then detects the falling edge of each enable. Each such edge, when this slave is selected, produces a one-cycle internal write strobe or read request.

Several devices share the address, data and enable lines. While the host boots it reads from other devices under their own chip selects. For that reason the slave asks for the data pads only while its own chip select pattern and the read enable are both present, and never during reset. The pad buffer itself lives at chip level, so the data bus reaches this block as an input word, an output word and a drive enable.

Registers are word-addressed by address bits [15:1]. Indices beyond the bank read as zero, and writes to them change nothing.

Top module: `lbus_slave`

## Requirements
- R1: The slave is selected only when the chip-select vector equals 3'b110 (bit 0 low, bits 2 and 1 high). For every other value, writes leave all registers unchanged and the drive enable stays low.
- R2: `bus_dq_oe` is high exactly while `bus_oe_n` is low, `bus_cs_n` equals 3'b110 and `rst` is low. It follows the pins without waiting for the clock, and it stays low throughout a write.
- R3: While the synchronous active-high `rst` is asserted, `bus_dq_oe` is low. After reset, every register reads 16'h0000.
- R4: A write takes effect exactly once for each synchronized falling edge of `bus_we_n` while the slave is selected. The data word is taken as it stood at that edge, and later changes on `bus_dq_i` while `bus_we_n` stays low have no effect.
- R5: The address is taken at that same edge. Changing `bus_addr` while `bus_we_n` stays low writes nothing to the newly addressed register.
- R6: A read returns the register whose index is `bus_addr[15:1]`. Address bit 0 has no effect on reads or writes.
- R7: Indices of NUM_REGS (default 8) or above read back as 16'h0000. Writes to them alter no mapped register, including the register that the index would hit if its upper bits were dropped.
- R8: With the address and chip select stable at least three clock cycles before `bus_oe_n` falls, `bus_dq_o` holds the addressed register's value no later than four clock cycles after the fall.
- R9: Reads never modify any register. Register contents change only on a write strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | FPGA clock that samples the host bus |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Host address; bits [15:1] pick the register |
| bus_cs_n | input | 3 | Active-low chip selects; 3'b110 selects this slave |
| bus_oe_n | input | 1 | Active-low host read enable |
| bus_we_n | input | 1 | Active-low host write enable |
| bus_dq_i | input | 16 | Data bus as seen at the pad input |
| bus_dq_o | output | 16 | Read data for the pad output |
| bus_dq_oe | output | 1 | Pad drive enable for the data bus |

## Verification
The bench builds the block with its defaults: eight registers, a 16-bit bus and two synchronizer stages. That small bank lets every register be written and read back with address bit 0 both set and clear. It also lets all eight chip-select patterns be swept against one register, and lets the first index past the bank be probed together with the top index, so that an aliasing write would surface in a mapped register. The two-stage depth fixes the read latency at a known count, which the bench samples exactly four cycles after the read enable falls.

// File: rtl/lbus_slave.sv
module lbus_slave #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CS_W = 3,
  parameter logic [CS_W-1:0] SEL_CODE = 3'b110,
  parameter int NUM_REGS = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CS_W-1:0]   bus_cs_n,
  input  logic              bus_oe_n,
  input  logic              bus_we_n,
  input  logic [DATA_W-1:0] bus_dq_i,
  output logic [DATA_W-1:0] bus_dq_o,
  output logic              bus_dq_oe
);

  localparam int IDX_W  = ADDR_W - 1;
  localparam int SLOT_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam int BUS_W  = IDX_W + DATA_W + CS_W + 2;
  localparam logic [BUS_W-1:0] IDLE = {{IDX_W{1'b0}}, {DATA_W{1'b0}}, {CS_W{1'b1}}, 2'b11};
  localparam logic [IDX_W:0] LIMIT = (IDX_W + 1)'(NUM_REGS);

  logic unused_lsb;
  assign unused_lsb = bus_addr[0];

  logic [BUS_W-1:0] stage [SYNC_STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SYNC_STAGES; i++) stage[i] <= IDLE;
    end else begin
      stage[0] <= {bus_addr[ADDR_W-1:1], bus_dq_i, bus_cs_n, bus_oe_n, bus_we_n};
      for (int i = 1; i < SYNC_STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  logic [IDX_W-1:0]  s_idx;
  logic [DATA_W-1:0] s_data;
  logic [CS_W-1:0]   s_cs_n;
  logic              s_oe_n, s_we_n;
  assign {s_idx, s_data, s_cs_n, s_oe_n, s_we_n} = stage[SYNC_STAGES-1];

  logic oe_prev, we_prev;
  always_ff @(posedge clk) begin
    if (rst) begin
      oe_prev <= 1'b1;
      we_prev <= 1'b1;
    end else begin
      oe_prev <= s_oe_n;
      we_prev <= s_we_n;
    end
  end

  logic sel_s, wr_stb, rd_stb, hit;
  logic [SLOT_W-1:0] slot;
  assign sel_s  = (s_cs_n == SEL_CODE);
  assign wr_stb = we_prev & ~s_we_n & sel_s;
  assign rd_stb = oe_prev & ~s_oe_n & sel_s;
  assign hit    = ({1'b0, s_idx} < LIMIT);
  assign slot   = s_idx[SLOT_W-1:0];

  logic [DATA_W-1:0] regs [NUM_REGS];
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
    end else if (wr_stb && hit) begin
      for (int i = 0; i < NUM_REGS; i++)
        if (slot == SLOT_W'(i)) regs[i] <= s_data;
    end
  end

  logic [DATA_W-1:0] rdata;
  always_ff @(posedge clk) begin
    if (rst)         rdata <= '0;
    else if (rd_stb) rdata <= hit ? regs[slot] : '0;
  end

  assign bus_dq_o  = rdata;
  assign bus_dq_oe = ~rst & ~bus_oe_n & (bus_cs_n == SEL_CODE);

  logic [NUM_REGS*DATA_W-1:0] regs_flat;
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
    assign regs_flat[g*DATA_W +: DATA_W] = regs[g];
  end

endmodule

// File: rtl/lbus_slave_chk.sv
module lbus_slave_chk #(
  parameter int DATA_W = 16,
  parameter int NUM_REGS = 8
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       bus_dq_oe,
  input logic                       wr_stb,
  input logic                       rd_stb,
  input logic [NUM_REGS*DATA_W-1:0] regs_flat
);

  AST_RST_HIZ: assert property (@(posedge clk) rst |-> !bus_dq_oe); // R3
  AST_RST_CLEAR: assert property (@(posedge clk) $past(rst) |-> (regs_flat == '0)); // R3
  AST_WR_ONCE: assert property (@(posedge clk) disable iff (rst) wr_stb |=> !wr_stb); // R4
  AST_RD_ONCE: assert property (@(posedge clk) disable iff (rst) rd_stb |=> !rd_stb); // R8
  AST_REGS_HOLD: assert property (@(posedge clk) disable iff (rst) !wr_stb |=> $stable(regs_flat)); // R9

endmodule

bind lbus_slave lbus_slave_chk #(
  .DATA_W(DATA_W),
  .NUM_REGS(NUM_REGS)
) u_chk (
  .clk(clk),
  .rst(rst),
  .bus_dq_oe(bus_dq_oe),
  .wr_stb(wr_stb),
  .rd_stb(rd_stb),
  .regs_flat(regs_flat)
);

// File: tb/lbus_slave_tb.sv
module lbus_slave_tb;
  localparam int N = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst;
  logic [15:0] addr;
  logic [2:0]  cs_n;
  logic        oe_n, we_n;
  logic [15:0] dq_i;
  logic [15:0] dq_o;
  logic        dq_oe;

  lbus_slave u_dut (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_cs_n(cs_n),
    .bus_oe_n(oe_n), .bus_we_n(we_n), .bus_dq_i(dq_i),
    .bus_dq_o(dq_o), .bus_dq_oe(dq_oe)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  logic [15:0] model [N];

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic go_idle();
    cs_n = 3'b111;
    oe_n = 1'b1;
    we_n = 1'b1;
  endtask

  task automatic host_write(logic [2:0] cs, logic [15:0] a, logic [15:0] d);
    @(negedge clk);
    addr = a; dq_i = d; cs_n = cs;
    wait_cyc(3);
    we_n = 1'b0;
    #1;
    check("R2 no drive while writing", {15'b0, dq_oe}, 16'h0);
    wait_cyc(6);
    we_n = 1'b1;
    wait_cyc(3);
    cs_n = 3'b111;
    wait_cyc(3);
    if (cs == 3'b110 && a[15:1] < N) model[a[3:1]] = d;
  endtask

  task automatic host_read(logic [2:0] cs, logic [15:0] a, output logic [15:0] d, output logic en);
    @(negedge clk);
    addr = a; cs_n = cs;
    wait_cyc(3);
    oe_n = 1'b0;
    wait_cyc(6);
    d = dq_o;
    en = dq_oe;
    oe_n = 1'b1;
    wait_cyc(3);
    cs_n = 3'b111;
    wait_cyc(3);
  endtask

  task automatic expect_read(string req, logic [15:0] a, logic [15:0] e);
    logic [15:0] d;
    logic en;
    host_read(3'b110, a, d, en);
    check({req, " drive"}, {15'b0, en}, 16'h1);
    check(req, d, e);
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R8 watchdog actual=hung expected=done");
      report();
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic en;
    for (int i = 0; i < N; i++) model[i] = 16'h0;
    rst = 1'b1; addr = 16'h0; dq_i = 16'h0;
    go_idle();
    wait_cyc(2);
    cs_n = 3'b110; oe_n = 1'b0;
    #1;
    check("R3 no drive in reset", {15'b0, dq_oe}, 16'h0);
    wait_cyc(3);
    go_idle();
    rst = 1'b0;
    wait_cyc(4);

    for (int i = 0; i < N; i++) expect_read("R3 reset value", 16'(i * 2), 16'h0);

    @(negedge clk);
    cs_n = 3'b110; oe_n = 1'b1;
    #1; check("R2 select without read", {15'b0, dq_oe}, 16'h0);
    oe_n = 1'b0;
    #1; check("R2 select with read", {15'b0, dq_oe}, 16'h1);
    cs_n = 3'b111;
    #1; check("R2 read without select", {15'b0, dq_oe}, 16'h0);
    go_idle();
    wait_cyc(4);

    for (int i = 0; i < N; i++)
      host_write(3'b110, 16'(i * 2 + (i & 1)), 16'hA500 ^ 16'(i * 16'h1111));
    for (int i = 0; i < N; i++)
      expect_read("R6 index from bits 15:1", 16'(i * 2 + ((i & 1) ^ 1)), model[i]);

    for (int c = 0; c < 8; c++) begin
      if (c != 6) begin
        host_write(3'(c), 16'h0006, 16'hDEAD ^ 16'(c));
        host_read(3'(c), 16'h0006, d, en);
        check("R1 foreign select not driven", {15'b0, en}, 16'h0);
        expect_read("R1 foreign write ignored", 16'h0006, model[3]);
      end
    end

    host_write(3'b110, 16'h0010, 16'h1234);
    host_write(3'b110, 16'hFFFE, 16'h5678);
    expect_read("R7 first unmapped index", 16'h0010, 16'h0);
    expect_read("R7 top unmapped index", 16'hFFFF, 16'h0);
    for (int i = 0; i < N; i++) expect_read("R7 no aliasing", 16'(i * 2), model[i]);

    @(negedge clk);
    addr = 16'h0004; dq_i = 16'h0F0F; cs_n = 3'b110;
    wait_cyc(3);
    we_n = 1'b0;
    wait_cyc(6);
    dq_i = 16'hF0F0; addr = 16'h000A;
    wait_cyc(8);
    we_n = 1'b1;
    wait_cyc(3);
    go_idle();
    wait_cyc(3);
    model[2] = 16'h0F0F;
    expect_read("R4 data taken at edge", 16'h0004, model[2]);
    expect_read("R5 address taken at edge", 16'h000A, model[5]);

    expect_read("R8 prime", 16'h0000, model[0]);
    @(negedge clk);
    addr = 16'h0002; cs_n = 3'b110;
    wait_cyc(3);
    oe_n = 1'b0;
    wait_cyc(4);
    check("R8 data within four cycles", dq_o, model[1]);
    go_idle();
    wait_cyc(4);

    for (int k = 0; k < 6; k++) expect_read("R9 repeated read", 16'h0008, model[4]);
    for (int i = 0; i < N; i++) expect_read("R9 reads leave bank intact", 16'(i * 2), model[i]);

    finished = 1'b1;
    report();
    $finish;
  end
endmodule